// File: doc/BRIEF.md
# Double-Buffered Timer Compare Unit

This block sits beside a 16-bit timer counter and holds one compare value for it. Software loads the value through an 8-bit data bus. It writes the upper byte first, which is parked in a holding byte, and then the lower byte, which delivers the whole 16-bit word in a single step. On every timer clock the unit compares the counter against its active value. An equality raises a match indication, and one timer clock later a sticky flag is set. The flag can drive an interrupt request.

A two-bit update mode decides when a newly committed word becomes active. In the immediate mode the word goes straight into the active register. In the two buffered modes the word waits in a buffer and is copied across only when the counter reports its upper or its lower extreme. This keeps waveform periods glitch-free while software rewrites the value. The active value is also driven out as a period limit, so a counter can use it as its wrap point.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the active value, the buffer, the holding byte, the match output, the flag and the interrupt request are all 0. A lower-byte write issued straight after reset therefore yields an active value whose upper byte is 0.
- R2: `match` is updated only on cycles where `tick` is 1. It takes the value (`cnt` == active value) at that edge and holds it until the next ticked edge.
- R3: A bus write with `wr_hi`=1 stores `wr_data` in the holding byte only. The active value does not change at that edge.
- R4: With `upd_mode` 2'b00 or 2'b11 (immediate), a write with `wr_hi`=0 loads {holding byte, `wr_data`} into the active register at that edge, and into the buffer as well.
- R5: With `upd_mode` 2'b01, a lower-byte write loads the buffer only. The active register copies the buffer at an edge where `tick` and `at_top` are both 1, and at no other edge.
- R6: With `upd_mode` 2'b10, the same as R5, except that the copy happens at an edge where `tick` and `at_bottom` are both 1.
- R7: `flag` is set at a ticked edge where `match` is 1 (one timer clock after the equality). It then stays set until it is cleared.
- R8: `flag` clears at an edge where `flag_clr` or `irq_ack` is 1. If a set from R7 falls on the same edge, the flag ends up set.
- R9: `irq` is 1 exactly when `flag` and `irq_en` are both 1.
- R10: `top_val` always equals the active compare value.
- R11: When a lower-byte commit and a buffered update strobe fall on the same edge, the active register takes the buffer content from before that edge, and the buffer takes the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable; one pulse per counter step |
| cnt | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at its upper extreme |
| at_bottom | input | 1 | Counter is at zero |
| upd_mode | input | 2 | 00/11 immediate, 01 update at top, 10 update at bottom |
| wr_en | input | 1 | Bus write strobe |
| wr_hi | input | 1 | 1 selects the upper byte, 0 the lower byte |
| wr_data | input | 8 | Bus write data |
| flag_clr | input | 1 | Software clear of the flag (write of one) |
| irq_ack | input | 1 | Interrupt serviced; clears the flag |
| irq_en | input | 1 | Interrupt enable |
| active_val | output | 16 | Compare value currently in force |
| top_val | output | 16 | Period limit offered to the counter |
| match | output | 1 | Registered equality indication |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default 8-bit bus, which gives a 16-bit compare word. It steps its own counter through a short period of 41 values, wrapping from 40 to 0. Because the period is short and most random upper bytes are zero, equalities, top strobes and bottom strobes all occur many times in a few thousand cycles. Each of the four update modes is held for a stretch of random writes, clears and acknowledges. This covers commits that coincide with strobes and clears that coincide with sets, alongside the directed cases for those same collisions.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [1:0] {
    UPD_NOW = 2'b00,
    UPD_TOP = 2'b01,
    UPD_BOT = 2'b10,
    UPD_RSV = 2'b11
  } upd_mode_e;

  // buffered modes defer the commit to a counter extreme
  function automatic logic mode_buffered(upd_mode_e m);
    return (m == UPD_TOP) || (m == UPD_BOT);
  endfunction

  // edge at which the buffer is copied into the active register
  function automatic logic upd_strobe(upd_mode_e m, logic tk, logic top, logic bot);
    return tk && (((m == UPD_TOP) && top) || ((m == UPD_BOT) && bot));
  endfunction

  // next flag state: a set wins over any clear on the same edge
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/tcmp_wr_path.sv
module tcmp_wr_path #(
  parameter int BUS_W = 8,
  localparam int WORD_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  temp_q,
  output logic              commit,
  output logic [WORD_W-1:0] commit_val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      temp_q <= '0;
    else if (wr_en && wr_hi)
      temp_q <= wr_data;
  end

  assign commit     = wr_en && !wr_hi;
  assign commit_val = {temp_q, wr_data};

endmodule

// File: rtl/tcmp_cmp_regs.sv
module tcmp_cmp_regs
  import tcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] commit_val,
  input  upd_mode_e    mode,
  input  logic         tick,
  input  logic         at_top,
  input  logic         at_bottom,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         upd_stb
);

  logic buffered;

  assign buffered = mode_buffered(mode);
  assign upd_stb  = upd_strobe(mode, tick, at_top, at_bottom);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      buf_q <= '0;
    else if (commit)
      buf_q <= commit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_q <= '0;
    else if (buffered) begin
      if (upd_stb)
        act_q <= buf_q;
    end else if (commit)
      act_q <= commit_val;
  end

endmodule

// File: rtl/tcmp_match_flag.sv
module tcmp_match_flag
  import tcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] act,
  input  logic         flag_clr,
  input  logic         irq_ack,
  input  logic         irq_en,
  output logic         eq,
  output logic         match_q,
  output logic         flag_set,
  output logic         flag_q,
  output logic         irq
);

  assign eq       = (cnt == act);
  assign flag_set = tick && match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      match_q <= 1'b0;
    else if (tick)
      match_q <= eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= flag_next(flag_q, flag_set, flag_clr || irq_ack);
  end

  assign irq = flag_q && irq_en;

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic [1:0]       upd_mode,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             flag_clr,
  input  logic             irq_ack,
  input  logic             irq_en,
  output logic [CNT_W-1:0] active_val,
  output logic [CNT_W-1:0] top_val,
  output logic             match,
  output logic             flag,
  output logic             irq
);

  // named internal events, visible to the bound checker
  logic [BUS_W-1:0] temp_q;
  logic             commit;
  logic [CNT_W-1:0] commit_val;
  logic [CNT_W-1:0] buf_q;
  logic             upd_stb;
  logic             eq;
  logic             flag_set;
  upd_mode_e        mode;

  assign mode = upd_mode_e'(upd_mode);

  tcmp_wr_path #(.BUS_W(BUS_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_hi      (wr_hi),
    .wr_data    (wr_data),
    .temp_q     (temp_q),
    .commit     (commit),
    .commit_val (commit_val)
  );

  tcmp_cmp_regs #(.W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .commit_val (commit_val),
    .mode       (mode),
    .tick       (tick),
    .at_top     (at_top),
    .at_bottom  (at_bottom),
    .buf_q      (buf_q),
    .act_q      (active_val),
    .upd_stb    (upd_stb)
  );

  tcmp_match_flag #(.W(CNT_W)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt      (cnt),
    .act      (active_val),
    .flag_clr (flag_clr),
    .irq_ack  (irq_ack),
    .irq_en   (irq_en),
    .eq       (eq),
    .match_q  (match),
    .flag_set (flag_set),
    .flag_q   (flag),
    .irq      (irq)
  );

  assign top_val = active_val;

endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk #(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       upd_mode,
  input logic             wr_en,
  input logic             wr_hi,
  input logic [BUS_W-1:0] wr_data,
  input logic [BUS_W-1:0] temp_q,
  input logic             upd_stb,
  input logic             flag_clr,
  input logic             irq_ack,
  input logic             match,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] active_val
);

  // R2
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(match));

  // R3
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi && (upd_mode == 2'b00 || upd_mode == 2'b11)) |=> $stable(active_val));

  // R4
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi && (upd_mode == 2'b00 || upd_mode == 2'b11))
      |=> active_val == $past({temp_q, wr_data}));

  // R5
  buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((upd_mode == 2'b01 || upd_mode == 2'b10) && !upd_stb) |=> $stable(active_val));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match) |=> flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr || irq_ack) && !(tick && match)) |=> !flag);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

endmodule

bind tcmp_unit tcmp_unit_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .upd_mode   (upd_mode),
  .wr_en      (wr_en),
  .wr_hi      (wr_hi),
  .wr_data    (wr_data),
  .temp_q     (temp_q),
  .upd_stb    (upd_stb),
  .flag_clr   (flag_clr),
  .irq_ack    (irq_ack),
  .match      (match),
  .flag       (flag),
  .irq        (irq),
  .active_val (active_val)
);

// File: tb/tcmp_unit_test.sv
module tcmp_unit_test;

  localparam int BUS_W = 8;
  localparam int CNT_W = 2 * BUS_W;
  localparam int PER   = 40;
  localparam time CLK_P = 20ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             at_top, at_bottom;
  logic [1:0]       upd_mode = 2'b00;
  logic             wr_en = 1'b0;
  logic             wr_hi = 1'b0;
  logic [BUS_W-1:0] wr_data = '0;
  logic             flag_clr = 1'b0;
  logic             irq_ack = 1'b0;
  logic             irq_en = 1'b0;
  logic [CNT_W-1:0] active_val, top_val;
  logic             match, flag, irq;

  int n_chk = 0;
  int n_err = 0;

  assign at_top    = (cnt == CNT_W'(PER));
  assign at_bottom = (cnt == '0);

  always #(CLK_P / 2) clk = ~clk;

  tcmp_unit #(.BUS_W(BUS_W)) uut (
    .clk, .rst_n, .tick, .cnt, .at_top, .at_bottom, .upd_mode,
    .wr_en, .wr_hi, .wr_data, .flag_clr, .irq_ack, .irq_en,
    .active_val, .top_val, .match, .flag, .irq
  );

  // reference model written from the requirements
  logic [BUS_W-1:0] m_temp;
  logic [CNT_W-1:0] m_buf, m_act;
  logic             m_match, m_flag;

  function automatic logic buffered_f(logic [1:0] m);
    return m == 2'b01 || m == 2'b10;
  endfunction

  function automatic logic strobe_f(logic [1:0] m, logic tk, logic t, logic b);
    if (!tk) return 1'b0;
    if (m == 2'b01) return t;
    if (m == 2'b10) return b;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_temp <= '0; m_buf <= '0; m_act <= '0; m_match <= 1'b0; m_flag <= 1'b0;
    end else begin
      if (wr_en && wr_hi) m_temp <= wr_data;
      if (wr_en && !wr_hi) m_buf <= {m_temp, wr_data};
      if (buffered_f(upd_mode)) begin
        if (strobe_f(upd_mode, tick, at_top, at_bottom)) m_act <= m_buf;
      end else if (wr_en && !wr_hi) m_act <= {m_temp, wr_data};
      if (tick) m_match <= (cnt == m_act);
      if (tick && m_match) m_flag <= 1'b1;
      else if (flag_clr || irq_ack) m_flag <= 1'b0;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    string at;
    at = (upd_mode == 2'b01) ? "R5 active" : (upd_mode == 2'b10) ? "R6 active" : "R4 active";
    check(at, 32'(active_val), 32'(m_act));
    check("R10 top_val", 32'(top_val), 32'(m_act));
    check("R2 match", 32'(match), 32'(m_match));
    check("R7 flag", 32'(flag), 32'(m_flag));
    check("R9 irq", 32'(irq), 32'(m_flag && irq_en));
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_bus();
    wr_en = 1'b0; wr_hi = 1'b0; flag_clr = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic bus_wr(logic hi, logic [BUS_W-1:0] d);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 active", 32'(active_val), 0);
    check("R1 match", 32'(match), 0);
    check("R1 flag", 32'(flag), 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 holding byte is zero: lower byte alone
    upd_mode = 2'b00;
    bus_wr(1'b0, 8'h05);
    check("R1 temp", 32'(active_val), 32'h0005);
    // R3 upper byte does not reach the active value
    bus_wr(1'b1, 8'h12);
    check("R3 hi", 32'(active_val), 32'h0005);
    // R4 immediate commit
    bus_wr(1'b0, 8'h34);
    check("R4 commit", 32'(active_val), 32'h1234);

    // R5 update at top
    upd_mode = 2'b01;
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'h0A);
    check("R5 wait", 32'(active_val), 32'h1234);
    cnt = CNT_W'(PER); tick = 1'b1;
    cyc();
    check("R5 load", 32'(active_val), 32'h000A);
    tick = 1'b0;

    // R11 commit and strobe on the same edge
    bus_wr(1'b0, 8'h0C);
    tick = 1'b1; wr_en = 1'b1; wr_hi = 1'b0; wr_data = 8'h0D;
    cyc();
    check("R11 old", 32'(active_val), 32'h000C);
    wr_en = 1'b0;
    cyc();
    check("R11 new", 32'(active_val), 32'h000D);
    tick = 1'b0;

    // R6 update at bottom
    upd_mode = 2'b10;
    bus_wr(1'b0, 8'h07);
    tick = 1'b1;
    cyc();
    check("R6 top ignored", 32'(active_val), 32'h000D);
    cnt = '0;
    cyc();
    check("R6 load", 32'(active_val), 32'h0007);
    tick = 1'b0;

    // R7 R8 R9 flag behaviour
    upd_mode = 2'b00;
    bus_wr(1'b0, 8'h03);
    check("R10 top", 32'(top_val), 32'h0003);
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
    check("R8 sw clear", 32'(flag), 0);
    cnt = 16'd3; tick = 1'b1;
    cyc();
    check("R2 match", 32'(match), 1);
    check("R7 delayed", 32'(flag), 0);
    cnt = 16'd4;
    cyc();
    check("R7 set", 32'(flag), 1);
    tick = 1'b0; irq_en = 1'b0;
    cyc();
    check("R7 sticky", 32'(flag), 1);
    check("R9 masked", 32'(irq), 0);
    irq_en = 1'b1;
    #1;
    check("R9 raised", 32'(irq), 1);
    irq_ack = 1'b1;
    cyc();
    irq_ack = 1'b0;
    check("R8 ack", 32'(flag), 0);
    cnt = 16'd3; tick = 1'b1;
    cyc();
    cnt = 16'd4; flag_clr = 1'b1;
    cyc();
    check("R8 set wins", 32'(flag), 1);
    flag_clr = 1'b0; tick = 1'b0;
    cyc();

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if (tick) cnt = (cnt >= CNT_W'(PER)) ? '0 : cnt + 1'b1;
      upd_mode = 2'((i / 500) % 4);
      tick     = ($urandom % 4) != 0;
      wr_en    = ($urandom % 6) == 0;
      wr_hi    = $urandom % 2;
      if (wr_hi) wr_data = (($urandom % 8) == 0) ? BUS_W'($urandom) : '0;
      else       wr_data = BUS_W'($urandom % (PER + 4));
      flag_clr = ($urandom % 10) == 0;
      irq_ack  = ($urandom % 12) == 0;
      if (($urandom % 16) == 0) irq_en = ~irq_en;
      cyc();
    end
    idle_bus();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule